// File: doc/BRIEF.md
# Software Forced Interrupt Register

This block holds one force bit per interrupt priority level. Software sets these bits to raise interrupt requests of its own. A typical use is a service routine that handles the urgent part of its work at once, then sets the force bit of a lower level so that the remaining work runs later. Software can change the bits in two ways. It can read and write the main register directly. It can also write to a set alias or a clear alias: a single plain write of a level number to an alias turns on, or turns off, exactly one bit, with no read-modify-write.

Each force bit that is on drives a request into the selection logic of its level. Within a level the hardware sources are ranked by index, and source 0 is the most urgent. The forced request ranks below every hardware source, so it wins its level only when no hardware source of that level is asking. For each level the block reports whether any request is pending, and the index of the source that wins. The forced source has index SRCS, one past the last hardware source. Choosing between levels, generating vectors and the handshake with the processor are done elsewhere.

Top module: `swint_force`

## Requirements
- R1: While reset (rst_ni low) is applied, all force bits clear. After reset, the main register reads 0 and force_req_o is 0.
- R2: A write to address 0 (main register) loads force bit L from wr_data_i[L] for L = 1..7. Bit 0 of the main register is unused, so a read of address 0 returns the force bits in bits 7..1 and a 0 in bit 0.
- R3: A write to address 1 (set alias) sets force bit L, where L = wr_data_i[2:0], and leaves the other bits unchanged. L = 0 has no effect, and wr_data_i[7:3] is ignored.
- R4: A write to address 2 (clear alias) clears force bit L, where L = wr_data_i[2:0], and leaves the other bits unchanged. L = 0 has no effect, and wr_data_i[7:3] is ignored.
- R5: Addresses 1, 2 and 3 read as 0. A write to address 3 changes nothing.
- R6: force_req_o bit L-1 equals force bit L. It takes a written value on the clock edge that performs the write.
- R7: lvl_req_o bit L-1 is 1 exactly when force bit L is set or any hardware request of level L is set. The hardware request for source s of level L is hw_req_i[(L-1)*4 + s].
- R8: lvl_src_o[(L-1)*3 +: 3] gives the lowest index s of the active hardware sources of level L. If no hardware source of level L is active and force bit L is set, it gives 4. If nothing is pending, it gives 0.
- R9: In a cycle where wr_en_i is low, the force bits keep their value whatever addr_i and wr_data_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (2) | Register select: 0 main, 1 set alias, 2 clear alias |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_data_i | input | DATA_W (8) | Write data |
| rd_data_o | output | DATA_W (8) | Read data for addr_i, combinational |
| hw_req_i | input | LEVELS*SRCS (28) | Hardware requests, SRCS bits per level, level 1 lowest slice |
| force_req_o | output | LEVELS (7) | Forced request per level, bit 0 is level 1 |
| lvl_req_o | output | LEVELS (7) | Any request pending per level |
| lvl_src_o | output | LEVELS*IDX_W (21) | Winning source index per level |

## Verification
The assertions assume that the bus carries at most one write per cycle, and that its inputs are stable around the rising edge. They also assume that the level number written to an alias never exceeds LEVELS, which always holds with seven levels and a 3-bit field. The bench changes inputs only on the falling edge and drives a single strobe. It sweeps every data byte through each address, starting from several force patterns, and pairs every force pattern with sixteen rotating hardware patterns so that each level sees every mix of hardware and forced requests.

// File: rtl/swint_pkg.sv
package swint_pkg;

   // Register slots on the small configuration bus
   typedef enum int unsigned {
      SLOT_FORCE = 0,
      SLOT_SET   = 1,
      SLOT_CLEAR = 2
   } swint_slot_e;

   // Bits needed to name a source index including the forced slot
   function automatic int src_idx_width(input int srcs);
      return $clog2(srcs + 1);
   endfunction

endpackage

// File: rtl/swint_force_regs.sv
module swint_force_regs #(
   parameter int LEVELS = 7,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int LVL_W  = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [LEVELS:1]   frc_o
);
   import swint_pkg::*;

   localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(SLOT_FORCE);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SLOT_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(SLOT_CLEAR);

   logic [LEVELS:1]   frc_q;
   logic [LEVELS:1]   frc_d;
   logic [LEVELS:1]   set_vec;
   logic [LEVELS:1]   clr_vec;
   logic [LVL_W-1:0]  lvl_sel;
   logic [DATA_W-1:0] rd_word;

   assign lvl_sel = wr_data_i[LVL_W-1:0];

   // One-hot decode of the alias level; level 0 selects nothing
   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      for (int l = 1; l <= LEVELS; l++) begin
         if (wr_en_i && addr_i == A_SET && int'(lvl_sel) == l) set_vec[l] = 1'b1;
         if (wr_en_i && addr_i == A_CLR && int'(lvl_sel) == l) clr_vec[l] = 1'b1;
      end
   end

   // Direct load first, then alias updates; a set overrides a clear
   always_comb begin
      frc_d = frc_q;
      if (wr_en_i && addr_i == A_MAIN) frc_d = wr_data_i[LEVELS:1];
      frc_d = (frc_d & ~clr_vec) | set_vec;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) frc_q <= '0;
      else         frc_q <= frc_d;
   end

   // Read word layout: bit 0 unused, level L in bit L, upper padding zero
   if (DATA_W > LEVELS + 1) begin : g_rd_pad
      assign rd_word = {{(DATA_W-LEVELS-1){1'b0}}, frc_q, 1'b0};
   end else begin : g_rd_exact
      assign rd_word = {frc_q, 1'b0};
   end

   assign rd_data_o = (addr_i == A_MAIN) ? rd_word : '0;
   assign frc_o     = frc_q;

endmodule

// File: rtl/swint_lvl_pick.sv
module swint_lvl_pick #(
   parameter int SRCS  = 4,
   parameter int IDX_W = 3
) (
   input  logic [SRCS-1:0]  hw_i,
   input  logic             frc_i,
   output logic             req_o,
   output logic [IDX_W-1:0] idx_o
);
   // Lower hardware index wins; the forced request sits below all of them
   always_comb begin
      req_o = (|hw_i) | frc_i;
      idx_o = frc_i ? IDX_W'(SRCS) : '0;
      for (int s = SRCS - 1; s >= 0; s--) begin
         if (hw_i[s]) idx_o = IDX_W'(s);
      end
   end

endmodule

// File: rtl/swint_force.sv
module swint_force #(
   parameter int LEVELS = 7,
   parameter int SRCS   = 4,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int IDX_W  = swint_pkg::src_idx_width(SRCS)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    wr_en_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   output logic [DATA_W-1:0]       rd_data_o,
   input  logic [LEVELS*SRCS-1:0]  hw_req_i,
   output logic [LEVELS-1:0]       force_req_o,
   output logic [LEVELS-1:0]       lvl_req_o,
   output logic [LEVELS*IDX_W-1:0] lvl_src_o
);
   localparam int LVL_W = $clog2(LEVELS + 1);

   // Elaboration-time parameter checks
   if (LEVELS < 1) begin : g_bad_levels
      $error("swint_force: LEVELS must be at least 1");
   end
   if (SRCS < 1) begin : g_bad_srcs
      $error("swint_force: SRCS must be at least 1");
   end
   if (DATA_W < LEVELS + 1 || DATA_W < LVL_W) begin : g_bad_data
      $error("swint_force: DATA_W too narrow for the force bits");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("swint_force: ADDR_W must reach three slots");
   end
   if (IDX_W < $clog2(SRCS + 1)) begin : g_bad_idx
      $error("swint_force: IDX_W cannot encode the forced slot");
   end

   logic [LEVELS:1] frc;

   swint_force_regs #(
      .LEVELS(LEVELS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .addr_i    (addr_i),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data_o),
      .frc_o     (frc)
   );

   assign force_req_o = frc;

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      swint_lvl_pick #(.SRCS(SRCS), .IDX_W(IDX_W)) u_pick (
         .hw_i  (hw_req_i[l*SRCS +: SRCS]),
         .frc_i (frc[l+1]),
         .req_o (lvl_req_o[l]),
         .idx_o (lvl_src_o[l*IDX_W +: IDX_W])
      );
   end

endmodule

// File: rtl/swint_force_chk.sv
module swint_force_chk #(
   parameter int LEVELS = 7,
   parameter int SRCS   = 4,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int IDX_W  = 3
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic [ADDR_W-1:0]       addr_i,
   input logic                    wr_en_i,
   input logic [DATA_W-1:0]       wr_data_i,
   input logic [DATA_W-1:0]       rd_data_o,
   input logic [LEVELS*SRCS-1:0]  hw_req_i,
   input logic [LEVELS-1:0]       force_req_o,
   input logic [LEVELS-1:0]       lvl_req_o,
   input logic [LEVELS*IDX_W-1:0] lvl_src_o
);
   localparam int LVL_W = $clog2(LEVELS + 1);

   // R1
   reset_clears_chk: assert property (@(posedge clk_i)
      !rst_ni |=> force_req_o == '0);

   // R2
   main_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == ADDR_W'(0) |=> force_req_o == $past(wr_data_i[LEVELS:1]));

   // R5
   alias_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_i != '0 |-> rd_data_o == '0);

   // R9
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(force_req_o));

   for (genvar l = 0; l < LEVELS; l++) begin : g_lv
      // R3
      set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         wr_en_i && addr_i == ADDR_W'(1) && wr_data_i[LVL_W-1:0] == LVL_W'(l + 1)
         |=> force_req_o[l]);
      // R4
      clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         wr_en_i && addr_i == ADDR_W'(2) && wr_data_i[LVL_W-1:0] == LVL_W'(l + 1)
         |=> !force_req_o[l]);
      // R7
      forced_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         force_req_o[l] |-> lvl_req_o[l]);
      // R8
      forced_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         force_req_o[l] && hw_req_i[l*SRCS +: SRCS] == '0
         |-> lvl_src_o[l*IDX_W +: IDX_W] == IDX_W'(SRCS));
      // R8
      hw_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         hw_req_i[l*SRCS] |-> lvl_src_o[l*IDX_W +: IDX_W] == '0);
   end

endmodule

bind swint_force swint_force_chk #(
   .LEVELS(LEVELS), .SRCS(SRCS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .addr_i      (addr_i),
   .wr_en_i     (wr_en_i),
   .wr_data_i   (wr_data_i),
   .rd_data_o   (rd_data_o),
   .hw_req_i    (hw_req_i),
   .force_req_o (force_req_o),
   .lvl_req_o   (lvl_req_o),
   .lvl_src_o   (lvl_src_o)
);

// File: tb/swint_force_bench.sv
`timescale 1ns/1ps
module swint_force_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [27:0] hw_req = '0;
   logic [6:0]  force_req;
   logic [6:0]  lvl_req;
   logic [20:0] lvl_src;

   int total = 0;
   int fails = 0;
   logic [7:0] mdl;

   always #2 clk = ~clk;

   swint_force u_swint_force (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .rd_data_o(rd_data), .hw_req_i(hw_req),
      .force_req_o(force_req), .lvl_req_o(lvl_req), .lvl_src_o(lvl_src)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         2'd0: mdl = d & 8'hFE;
         2'd1: if (d[2:0] != 3'd0) mdl[d[2:0]] = 1'b1;
         2'd2: if (d[2:0] != 3'd0) mdl[d[2:0]] = 1'b0;
         default: ;
      endcase
   endtask

   task automatic read_all(input string tag);
      addr = 2'd0; #0.2;
      check(rd_data == mdl, {tag, " read main"}, 32'(rd_data), 32'(mdl));
      check(force_req == mdl[7:1], "R6 force_req_o", 32'(force_req), 32'(mdl[7:1]));
      for (int a = 1; a < 4; a++) begin
         addr = 2'(a); #0.2;
         check(rd_data == 8'h00, "R5 alias read", 32'(rd_data), 32'h0);
      end
      addr = 2'd0;
   endtask

   function automatic logic [2:0] exp_idx(input logic [3:0] h, input logic f);
      if (h != 4'd0) return 3'($clog2(32'(h & (~h + 4'd1))));
      return f ? 3'd4 : 3'd0;
   endfunction

   initial begin
      #(200000 * 4);
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      mdl = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(rd_data == 8'h00, "R1 reset read", 32'(rd_data), 32'h0);
      check(force_req == 7'h0, "R1 reset force_req_o", 32'(force_req), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      read_all("R1");

      // R2: every byte through the main register
      for (int v = 0; v < 256; v++) begin
         bus_write(2'd0, 8'(v));
         read_all("R2");
      end

      // R3 / R4: every byte through each alias from several start patterns
      foreach (mdl[i]) ;
      for (int st = 0; st < 3; st++) begin
         logic [7:0] start;
         start = (st == 0) ? 8'h00 : (st == 1) ? 8'hAA : 8'hFE;
         bus_write(2'd0, start);
         for (int d = 0; d < 256; d++) begin
            bus_write(2'd1, 8'(d));
            read_all("R3 set alias");
         end
         bus_write(2'd0, start);
         for (int d = 0; d < 256; d++) begin
            bus_write(2'd2, 8'(d));
            read_all("R4 clear alias");
         end
      end

      // R5: writes to the spare slot do nothing
      bus_write(2'd0, 8'h5A);
      for (int d = 0; d < 256; d += 17) begin
         bus_write(2'd3, 8'(d));
         read_all("R5 spare write");
      end

      // R9: no strobe, bus lines toggling
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         addr = 2'(k); wr_data = 8'(k * 37);
         @(negedge clk);
         addr = 2'd0; #0.2;
         check(rd_data == mdl, "R9 hold without strobe", 32'(rd_data), 32'(mdl));
      end

      // R7 / R8: each force pattern against rotating hardware patterns
      for (int f = 0; f < 128; f++) begin
         bus_write(2'd0, 8'(f << 1));
         for (int p = 0; p < 16; p++) begin
            logic [6:0]  e_req;
            logic [20:0] e_src;
            @(negedge clk);
            for (int l = 0; l < 7; l++) hw_req[l*4 +: 4] = 4'(p + l * 5);
            #0.2;
            for (int l = 0; l < 7; l++) begin
               logic [3:0] h;
               h = 4'(p + l * 5);
               e_req[l] = (h != 4'd0) || f[l];
               e_src[l*3 +: 3] = exp_idx(h, f[l]);
            end
            check(lvl_req == e_req, "R7 level pending", 32'(lvl_req), 32'(e_req));
            check(lvl_src == e_src, "R8 winning source", 32'(lvl_src), 32'(e_src));
         end
      end
      hw_req = '0;

      // R1: reset again in mid-run
      bus_write(2'd0, 8'hFE);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      mdl = '0;
      check(force_req == 7'h0, "R1 mid-run reset", 32'(force_req), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      read_all("R1 after reset");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule